// File: doc/BRIEF.md
# Timer Interrupt Line Router

This block sits between a bank of event-timer channels and the interrupt controller. Each channel raises a one-cycle expiry event. The block turns that event into either a held level or a one-cycle pulse on one of `N_LINES` interrupt lines. Each channel selects its line with its own route field. A channel drives nothing unless both its own enable and the global enable are set. Two outside interrupt sources, an interval timer and a real-time clock, normally pass straight through to two fixed lines: line 0 and line 8.

When legacy replacement is on, channel 0 takes over line 0 and channel 1 takes over line 8. The two outside sources are then cut off, and the block drops its interval-timer enable output. The real-time clock level is sampled on every cycle, in both modes. The cycle after replacement ends, line 8 therefore shows the clock's current level at once, with no wait for the clock's next change.

Top module: `tmr_irq_router`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every interrupt line is low and `pit_en_o` is high. The latched clock level starts at 0.
- R2: In normal mode, an expiry on channel c (`ch_fire_i[c]`) shows on line `ch_route_i[5c+4:5c]` two clock edges after the edge that samples it.
- R3: In legacy mode, channel 0 drives line 0 and channel 1 drives line 8, and their route fields are ignored. Channels 2 and up keep using their route fields.
- R4: In normal mode, `pit_i` shows on line 0 and `rtc_i` shows on line 8, each two edges after being sampled. In legacy mode neither input reaches any line.
- R5: `rtc_i` is latched on every edge in both modes. On the first cycle after legacy mode ends, line 8 equals the latched level.
- R6: One edge after `legacy_i` rises, `pit_en_o` is low and lines 0 and 8 are low for that cycle.
- R7: One edge after `legacy_i` falls, `pit_en_o` is high again and line 0 is low for that cycle.
- R8: `ch_level_i[c]=1` selects level type. A level-type channel sets a status bit on expiry and holds its line high until `ch_clr_i[c]` clears the bit. A line that is already high drops two edges after the clear is sampled.
- R9: `ch_level_i[c]=0` selects edge type. An edge-type channel drives its line high for exactly one cycle per expiry.
- R10: A channel drives its line only while `ch_en_i[c]` and `glb_en_i` are both high, checked on the edge that updates the lines. The status bit of a level-type channel survives while the channel is gated, so its line rises one edge after the gate opens.
- R11: Switching a channel from level to edge type lowers its line one edge later and drops its status bit.
- R12: All sources that target the same line in the same cycle are ORed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_en_i | input | 1 | Global interrupt enable |
| legacy_i | input | 1 | Legacy replacement mode |
| ch_en_i | input | N_CH | Per-channel interrupt enable |
| ch_level_i | input | N_CH | 1 = level type, 0 = edge type |
| ch_route_i | input | N_CH*5 | Route fields; channel c uses bits [5c+4:5c] |
| ch_fire_i | input | N_CH | One-cycle expiry events |
| ch_clr_i | input | N_CH | Status clear, one bit per channel |
| pit_i | input | 1 | Interval-timer interrupt input |
| rtc_i | input | 1 | Real-time clock interrupt input |
| irq_o | output | N_LINES | Registered interrupt lines |
| pit_en_o | output | 1 | Interval-timer enable, low in legacy mode |

## Verification
The assertions need `legacy_i`, `glb_en_i`, `pit_i` and `rtc_i` to be sampled cleanly on each edge. They also need the cycles just after reset to be ignored until enough history exists for every `$past` term. The checker holds each property off with an age counter until that history exists. The stimulus changes every input only at falling clock edges, and holds `legacy_i` and all enables low through reset. Mode changes in the random phase are rare, so each one is followed by stable stretches in which the pass-through and gating properties can fire.

// File: rtl/tmr_irq_router_pkg.sv
package tmr_irq_router_pkg;
  localparam int unsigned ROUTE_BITS  = 5;
  localparam int unsigned LINES_DEF   = 1 << ROUTE_BITS;
  localparam int unsigned PIT_LN_DEF  = 0;
  localparam int unsigned RTC_LN_DEF  = 8;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  typedef struct packed {
    logic enter;
    logic leave;
  } mode_evt_t;
endpackage

// File: rtl/tmr_irq_chan.sv
module tmr_irq_chan
  import tmr_irq_router_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic clr_i,
  input  logic level_i,
  output logic req_o
);
  trig_e trig;
  logic  sts_q, pls_q;

  assign trig = trig_e'(level_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= 1'b0;
      pls_q <= 1'b0;
    end else begin
      // status only lives in level type; leaving it drops the bit
      sts_q <= (trig == TRIG_LEVEL) & ((sts_q & ~clr_i) | fire_i);
      pls_q <= (trig == TRIG_EDGE) & fire_i;
    end
  end

  assign req_o = (trig == TRIG_LEVEL) ? sts_q : pls_q;
endmodule

// File: rtl/tmr_irq_legacy.sv
module tmr_irq_legacy
  import tmr_irq_router_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      legacy_i,
  input  logic      pit_i,
  input  logic      rtc_i,
  output logic      pit_q_o,
  output logic      rtc_q_o,
  output mode_evt_t evt_o,
  output logic      pit_en_o
);
  logic mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pit_q_o <= 1'b0;
      rtc_q_o <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      pit_q_o <= pit_i;
      rtc_q_o <= rtc_i;
      mode_q  <= legacy_i;
    end
  end

  assign evt_o.enter = legacy_i & ~mode_q;
  assign evt_o.leave = ~legacy_i & mode_q;
  assign pit_en_o    = ~mode_q;
endmodule

// File: rtl/tmr_irq_line_map.sv
module tmr_irq_line_map
  import tmr_irq_router_pkg::*;
#(
  parameter int unsigned N_CH     = 8,
  parameter int unsigned N_LINES  = LINES_DEF,
  parameter int unsigned ROUTE_W  = ROUTE_BITS,
  parameter int unsigned PIT_LINE = PIT_LN_DEF,
  parameter int unsigned RTC_LINE = RTC_LN_DEF
) (
  input  logic [N_CH-1:0]         req_i,
  input  logic [N_CH*ROUTE_W-1:0] route_i,
  input  logic                    legacy_i,
  input  logic                    pit_i,
  input  logic                    rtc_i,
  input  mode_evt_t               evt_i,
  output logic [N_LINES-1:0]      lines_o
);
  localparam int unsigned SPAN = 1 << ROUTE_W;

  logic [SPAN-1:0] wide;

  always_comb begin
    wide = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (req_i[c]) begin
        if (legacy_i && c == 0)      wide[PIT_LINE] = 1'b1;
        else if (legacy_i && c == 1) wide[RTC_LINE] = 1'b1;
        else                         wide[route_i[c*ROUTE_W +: ROUTE_W]] = 1'b1;
      end
    end
    if (!legacy_i) begin
      wide[PIT_LINE] = wide[PIT_LINE] | pit_i;
      wide[RTC_LINE] = wide[RTC_LINE] | rtc_i;
    end
    // mode switch cycle overrides the two shared lines
    if (evt_i.enter) begin
      wide[PIT_LINE] = 1'b0;
      wide[RTC_LINE] = 1'b0;
    end
    if (evt_i.leave) begin
      wide[PIT_LINE] = 1'b0;
      wide[RTC_LINE] = rtc_i;
    end
  end

  assign lines_o = wide[N_LINES-1:0];
endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
  import tmr_irq_router_pkg::*;
#(
  parameter int unsigned N_CH     = 8,
  parameter int unsigned N_LINES  = LINES_DEF,
  parameter int unsigned PIT_LINE = PIT_LN_DEF,
  parameter int unsigned RTC_LINE = RTC_LN_DEF
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       glb_en_i,
  input  logic                       legacy_i,
  input  logic [N_CH-1:0]            ch_en_i,
  input  logic [N_CH-1:0]            ch_level_i,
  input  logic [N_CH*ROUTE_BITS-1:0] ch_route_i,
  input  logic [N_CH-1:0]            ch_fire_i,
  input  logic [N_CH-1:0]            ch_clr_i,
  input  logic                       pit_i,
  input  logic                       rtc_i,
  output logic [N_LINES-1:0]         irq_o,
  output logic                       pit_en_o
);
  logic [N_CH-1:0]    req, req_gated;
  logic [N_LINES-1:0] lines_d, irq_q;
  logic               pit_q, rtc_q;
  mode_evt_t          evt;

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    tmr_irq_chan u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fire_i  (ch_fire_i[c]),
      .clr_i   (ch_clr_i[c]),
      .level_i (ch_level_i[c]),
      .req_o   (req[c])
    );
  end

  assign req_gated = req & ch_en_i & {N_CH{glb_en_i}};

  tmr_irq_legacy u_legacy (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .legacy_i (legacy_i),
    .pit_i    (pit_i),
    .rtc_i    (rtc_i),
    .pit_q_o  (pit_q),
    .rtc_q_o  (rtc_q),
    .evt_o    (evt),
    .pit_en_o (pit_en_o)
  );

  tmr_irq_line_map #(
    .N_CH     (N_CH),
    .N_LINES  (N_LINES),
    .ROUTE_W  (ROUTE_BITS),
    .PIT_LINE (PIT_LINE),
    .RTC_LINE (RTC_LINE)
  ) u_map (
    .req_i    (req_gated),
    .route_i  (ch_route_i),
    .legacy_i (legacy_i),
    .pit_i    (pit_q),
    .rtc_i    (rtc_q),
    .evt_i    (evt),
    .lines_o  (lines_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= lines_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/tmr_irq_router_chk.sv
module tmr_irq_router_chk #(
  parameter int unsigned N_LINES  = 32,
  parameter int unsigned PIT_LINE = 0,
  parameter int unsigned RTC_LINE = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               glb_en_i,
  input logic               legacy_i,
  input logic               pit_i,
  input logic               rtc_i,
  input logic [N_LINES-1:0] irq_o,
  input logic               pit_en_o
);
  localparam logic [N_LINES-1:0] SHARED =
    (N_LINES'(1) << PIT_LINE) | (N_LINES'(1) << RTC_LINE);

  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_enter_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && $rose(legacy_i)) |=> (!pit_en_o && !irq_o[PIT_LINE] && !irq_o[RTC_LINE]));

  assert_leave_restore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && $fell(legacy_i)) |=>
      (pit_en_o && !irq_o[PIT_LINE] && irq_o[RTC_LINE] == $past(rtc_i, 2)));

  assert_pass_through_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && !legacy_i && !$past(legacy_i) && !glb_en_i) |=>
      (irq_o[PIT_LINE] == $past(pit_i, 2) && irq_o[RTC_LINE] == $past(rtc_i, 2)));

  assert_global_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && !glb_en_i) |=> ((irq_o & ~SHARED) == '0));

  assert_pit_enable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0) |-> (pit_en_o == !$past(legacy_i)));
endmodule

bind tmr_irq_router tmr_irq_router_chk #(
  .N_LINES  (N_LINES),
  .PIT_LINE (PIT_LINE),
  .RTC_LINE (RTC_LINE)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .glb_en_i (glb_en_i),
  .legacy_i (legacy_i),
  .pit_i    (pit_i),
  .rtc_i    (rtc_i),
  .irq_o    (irq_o),
  .pit_en_o (pit_en_o)
);

// File: tb/tmr_irq_router_test.sv
`timescale 1ns/1ps
module tmr_irq_router_test;
  localparam int NC = 8;
  localparam int NL = 32;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          glb = 1'b0, leg = 1'b0, pit = 1'b0, rtc = 1'b0;
  logic [NC-1:0] en = '0, lvl = '0, fire = '0, clr = '0;
  logic [NC*RW-1:0] route = '0;
  logic [NL-1:0] irq_o;
  logic          pit_en_o;

  int checks = 0, failures = 0;
  bit cmp_on = 1'b0, done = 1'b0;

  logic [NC-1:0] m_sts, m_pls;
  logic [NL-1:0] m_irq;
  logic          m_pit, m_rtc, m_mode;

  always #2.5 clk = ~clk;

  tmr_irq_router uut (
    .clk_i(clk), .rst_ni(rst_n), .glb_en_i(glb), .legacy_i(leg),
    .ch_en_i(en), .ch_level_i(lvl), .ch_route_i(route), .ch_fire_i(fire),
    .ch_clr_i(clr), .pit_i(pit), .rtc_i(rtc), .irq_o(irq_o), .pit_en_o(pit_en_o)
  );

  function automatic logic [NL-1:0] next_lines();
    logic [NL-1:0] nx = '0;
    for (int c = 0; c < NC; c++) begin
      logic rq = lvl[c] ? m_sts[c] : m_pls[c];
      if (rq && en[c] && glb) begin
        if (leg && c == 0)      nx[0] = 1'b1;
        else if (leg && c == 1) nx[8] = 1'b1;
        else                    nx[route[c*RW +: RW]] = 1'b1;
      end
    end
    if (!leg) begin nx[0] |= m_pit; nx[8] |= m_rtc; end
    if (leg && !m_mode) begin nx[0] = 1'b0; nx[8] = 1'b0; end
    if (!leg && m_mode) begin nx[0] = 1'b0; nx[8] = m_rtc; end
    return nx;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sts = '0; m_pls = '0; m_irq = '0; m_pit = 0; m_rtc = 0; m_mode = 0;
    end else begin
      m_irq = next_lines();
      for (int c = 0; c < NC; c++) begin
        m_sts[c] = lvl[c] & ((m_sts[c] & ~clr[c]) | fire[c]);
        m_pls[c] = ~lvl[c] & fire[c];
      end
      m_pit = pit; m_rtc = rtc; m_mode = leg;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk(irq_o === m_irq, "R2 model lines", 64'(irq_o), 64'(m_irq));
      chk(pit_en_o === !m_mode, "R6 model pit_en", 64'(pit_en_o), 64'(!m_mode));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_fire(input logic [NC-1:0] f);
    fire = f; tick(1); fire = '0;
  endtask

  task automatic pulse_clr(input logic [NC-1:0] f);
    clr = f; tick(1); clr = '0;
  endtask

  task automatic set_route(input int c, input int ln);
    route[c*RW +: RW] = RW'(ln);
  endtask

  initial begin
    void'($urandom(32'd4711));
    tick(3);
    chk(irq_o == '0 && pit_en_o, "R1 during reset", {irq_o, 31'd0, pit_en_o}, 64'd1);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    tick(1);
    chk(irq_o == '0, "R1 lines after reset", 64'(irq_o), 64'd0);
    chk(pit_en_o == 1'b1, "R1 pit_en after reset", 64'(pit_en_o), 64'd1);

    glb = 1; en = '1; lvl = 8'b0100_1100;
    set_route(0, 20); set_route(1, 21); set_route(2, 12); set_route(3, 17);
    set_route(4, 5);  set_route(5, 25); set_route(6, 25); set_route(7, 30);
    tick(2);

    pulse_fire(8'h08); tick(1);
    chk(irq_o == (NL'(1) << 17), "R2 route to 17", 64'(irq_o), 64'(NL'(1) << 17));
    tick(4);
    chk(irq_o[17] == 1'b1, "R8 level held", 64'(irq_o[17]), 64'd1);
    pulse_clr(8'h08); tick(1);
    chk(irq_o[17] == 1'b0, "R8 cleared", 64'(irq_o[17]), 64'd0);

    pulse_fire(8'h10); tick(1);
    chk(irq_o[5] == 1'b1, "R9 edge pulse high", 64'(irq_o[5]), 64'd1);
    tick(1);
    chk(irq_o[5] == 1'b0, "R9 edge pulse one cycle", 64'(irq_o[5]), 64'd0);

    pulse_fire(8'h60); tick(1);
    chk(irq_o[25] == 1'b1, "R12 shared line", 64'(irq_o[25]), 64'd1);
    tick(1);
    chk(irq_o[25] == 1'b1, "R12 OR keeps level source", 64'(irq_o[25]), 64'd1);
    pulse_clr(8'h40); tick(1);
    chk(irq_o[25] == 1'b0, "R12 shared line released", 64'(irq_o[25]), 64'd0);

    en[2] = 1'b0;
    pulse_fire(8'h04); tick(1);
    chk(irq_o[12] == 1'b0, "R10 channel gated", 64'(irq_o[12]), 64'd0);
    en[2] = 1'b1; tick(1);
    chk(irq_o[12] == 1'b1, "R10 status kept while gated", 64'(irq_o[12]), 64'd1);
    glb = 1'b0; tick(1);
    chk(irq_o == '0, "R10 global gate", 64'(irq_o), 64'd0);
    glb = 1'b1; tick(1);
    chk(irq_o[12] == 1'b1, "R10 global reopen", 64'(irq_o[12]), 64'd1);

    lvl[2] = 1'b0; tick(1);
    chk(irq_o[12] == 1'b0, "R11 level to edge lowers", 64'(irq_o[12]), 64'd0);
    lvl[2] = 1'b1; tick(1);
    chk(irq_o[12] == 1'b0, "R11 status dropped", 64'(irq_o[12]), 64'd0);

    pit = 1; rtc = 1; tick(2);
    chk(irq_o[0] && irq_o[8], "R4 pass-through", {62'd0, irq_o[8], irq_o[0]}, 64'd3);

    leg = 1; tick(1);
    chk(!pit_en_o && !irq_o[0] && !irq_o[8], "R6 enter legacy",
        {61'd0, pit_en_o, irq_o[8], irq_o[0]}, 64'd0);
    tick(2);
    chk(!irq_o[0] && !irq_o[8], "R4 blocked in legacy", {62'd0, irq_o[8], irq_o[0]}, 64'd0);

    pulse_fire(8'h03); tick(1);
    chk(irq_o[0] && irq_o[8] && !irq_o[20] && !irq_o[21], "R3 legacy takeover",
        {60'd0, irq_o[21], irq_o[20], irq_o[8], irq_o[0]}, 64'd3);
    pulse_fire(8'h08); tick(1);
    chk(irq_o[17] == 1'b1, "R3 other channel keeps route", 64'(irq_o[17]), 64'd1);
    pulse_clr(8'h08);

    leg = 0; tick(1);
    chk(irq_o[8] == 1'b1, "R5 latched level on exit", 64'(irq_o[8]), 64'd1);
    chk(pit_en_o && !irq_o[0], "R7 leave legacy", {62'd0, pit_en_o, irq_o[0]}, 64'd2);
    tick(1);
    chk(irq_o[0] == 1'b1, "R7 pit resumes", 64'(irq_o[0]), 64'd1);

    leg = 1; tick(2); rtc = 0; tick(2);
    leg = 0; tick(1);
    chk(irq_o[8] == 1'b0, "R5 low level latched in legacy", 64'(irq_o[8]), 64'd0);
    pit = 0; tick(2);

    for (int i = 0; i < 4000; i++) begin
      fire = NC'($urandom);
      clr  = NC'($urandom & $urandom & $urandom);
      if ($urandom_range(15) == 0) en  = NC'($urandom);
      if ($urandom_range(15) == 0) lvl = NC'($urandom);
      if ($urandom_range(31) == 0) route = {$urandom, $urandom};
      if ($urandom_range(19) == 0) glb = ~glb;
      if ($urandom_range(39) == 0) leg = ~leg;
      if ($urandom_range(3) == 0)  pit = $urandom_range(1);
      if ($urandom_range(3) == 0)  rtc = $urandom_range(1);
      tick(1);
    end

    // back-to-back mode toggles
    fire = '0; clr = '0;
    for (int i = 0; i < 6; i++) begin
      leg = ~leg; rtc = i[0]; tick(1);
    end
    tick(3);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule